// File: doc/BRIEF.md
# Byte-Wide FIFO Port Bridge with Latency Flush

This block is the device side of an asynchronous, byte-wide FIFO port, of the kind found on USB-to-parallel bridges. External logic stores bytes into a transmit buffer with an active-low write strobe. It takes bytes out of a receive buffer with an active-low read strobe over a bus that the block drives only during a read.

Two flags pace the external side:
- `rx_avail_n` goes low while received data is waiting.
- `tx_busy` goes high while the transmit buffer is full or is still storing a byte.

On the other side, ready/valid byte ports stand in for the USB engine. A one-cycle `h_in_req` models a host data-in request. Each request drains up to one packet of transmit data.

A partly filled transmit buffer is released in one of two ways:
- A latency timer fires. It counts 1 ms ticks since the last write.
- `snd_wake` shows a rising edge. While the device is suspended, that same edge instead raises a one-cycle remote-wakeup request, provided remote wakeup is enabled.

The block is built around three state machines:
- **Write machine**:
  - `WR_IDLE` goes to `WR_HOLD1` on an accepted strobe fall.
  - `WR_HOLD1` goes to `WR_HOLD2`.
  - `WR_HOLD2` goes back to `WR_IDLE`.
  - Both hold states keep `tx_busy` high.
- **Read machine**:
  - `RD_IDLE` goes to `RD_DRIVE` on a strobe fall while data is present.
  - `RD_DRIVE` goes back to `RD_IDLE` on the strobe rise, which pops the head byte.
- **Drain machine**:
  - `TX_IDLE` goes to `TX_BURST` on a data-in request that finds the buffer eligible.
  - `TX_BURST` goes back to `TX_IDLE` after `BURST` bytes or when the buffer empties.

Top module: `fifo_bridge`

## Requirements
- R1: After reset these outputs are all low: `bus_oe`, `tx_busy`, `h_tx_valid` and `wake_req`. `rx_avail_n` is high and `h_rx_ready` is high.
- R2: `rx_avail_n` is low exactly while the receive buffer (`RX_DEPTH` bytes, default 128) holds at least one byte. `h_rx_ready` is low while that buffer is full.
- R3: A high-to-low transition of `ext_wr_n`, seen after a two-flop synchronizer, stores `bus_in` in the transmit buffer. Bytes leave that buffer in write order. `tx_busy` is high for at least two clock cycles after each accepted write.
- R4: `tx_busy` is high while the transmit buffer (`TX_DEPTH` bytes, default 385) is full. A write strobe while `tx_busy` is high stores nothing.
- R5: A read works as follows:
  - After a synchronized fall of `ext_rd_n` with data present, `bus_oe` is high and `bus_out` holds the head byte until the strobe rises.
  - The rise releases the bus and pops that byte.
  - A read with an empty buffer leaves `bus_oe` low.
- R6: A request on `h_in_req` moves min(`BURST`, count) bytes over `h_tx_*`, in order, when either the count is at least `BURST` or a flush is pending. Otherwise the request moves nothing.
- R7: The latency timer counts `ms_tick` pulses while the transmit buffer is non-empty and no flush is pending. When the count reaches the limit, a flush becomes pending. The limit is `lat_cfg` for values 1..255; `lat_cfg` = 0 selects `DEF_MS` (16).
- R8: Every accepted write restarts the latency count from zero.
- R9: When `suspended` is low, a rising edge on `snd_wake` makes every byte then present pending for flush, whatever the count.
- R10: A pending flush survives across requests until all the bytes present when it was triggered have been sent.
- R11: When `suspended` is high and `rwu_en` is high, a rising edge on `snd_wake` gives exactly one single-cycle `wake_req` pulse and triggers no flush.
- R12: When `suspended` is high and `rwu_en` is low, a rising edge on `snd_wake` has no effect: no `wake_req` and no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_wr_n | input | 1 | External write strobe, active low, asynchronous |
| ext_rd_n | input | 1 | External read strobe, active low, asynchronous |
| bus_in | input | 8 | Data from the external bus |
| bus_out | output | 8 | Data to the external bus |
| bus_oe | output | 1 | Bus output enable (low means high impedance) |
| rx_avail_n | output | 1 | Low while received data is waiting |
| tx_busy | output | 1 | High while the transmit buffer is full or storing a byte |
| snd_wake | input | 1 | Send-immediate / wakeup input, rising-edge sensitive |
| suspended | input | 1 | Device is suspended |
| rwu_en | input | 1 | Remote wakeup enabled |
| wake_req | output | 1 | One-cycle remote-wakeup request |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| lat_cfg | input | 8 | Latency limit in ms (0 selects the default) |
| h_rx_valid | input | 1 | Host byte valid toward the receive buffer |
| h_rx_data | input | 8 | Host byte |
| h_rx_ready | output | 1 | Receive buffer can accept a byte |
| h_in_req | input | 1 | Host data-in request pulse |
| h_tx_valid | output | 1 | Transmit byte valid toward the host |
| h_tx_data | output | 8 | Transmit byte |
| h_tx_ready | input | 1 | Host accepts the transmit byte |

## Verification
The assertions assume the following of the inputs:
- `bus_in` is stable from the write-strobe fall until the synchronized edge has been taken.
- Each strobe level is held for several clocks, so the synchronizer never loses an edge.
- `h_in_req` pulses only while the drain machine is idle.

The bench meets these assumptions in every task:
- Each strobe level is held for at least four cycles.
- Data is held for the whole write window.
- `h_in_req` is issued only after the previous drain window has finished.

The sweeps run on a small build (4-byte receive buffer, 8-byte transmit buffer, 3-byte packet). Expected counts and data come from a queue model kept in the bench.

// File: rtl/fb_pkg.sv
package fb_pkg;
    typedef enum logic [1:0] {WR_IDLE, WR_HOLD1, WR_HOLD2} wr_state_e;
    typedef enum logic {RD_IDLE, RD_DRIVE} rd_state_e;
    typedef enum logic {TX_IDLE, TX_BURST} tx_state_e;
endpackage

// File: rtl/fb_sync.sv
module fb_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fb_fifo.sv
module fb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/fb_latency.sv
module fb_latency #(
    parameter int DEF_MS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       restart,
    input  logic       armed,
    input  logic [7:0] cfg,
    output logic       expire
);
    logic [7:0] cnt;
    logic [7:0] limit;
    logic [8:0] cnt_next;

    assign limit    = (cfg == 8'd0) ? 8'(DEF_MS) : cfg;
    assign cnt_next = {1'b0, cnt} + 9'd1;
    assign expire   = armed && tick && !restart && (cnt_next >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (restart || !armed) cnt <= '0;
        else if (expire)        cnt <= '0;
        else if (tick)          cnt <= cnt_next[7:0];
    end
endmodule

// File: rtl/fifo_bridge.sv
module fifo_bridge
    import fb_pkg::*;
#(
    parameter int RX_DEPTH = 128,
    parameter int TX_DEPTH = 385,
    parameter int BURST    = 64,
    parameter int DEF_MS   = 16,
    localparam int RCW     = $clog2(RX_DEPTH + 1),
    localparam int TCW     = $clog2(TX_DEPTH + 1),
    localparam int SW      = $clog2(BURST + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_wr_n,
    input  logic       ext_rd_n,
    input  logic [7:0] bus_in,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    output logic       rx_avail_n,
    output logic       tx_busy,
    input  logic       snd_wake,
    input  logic       suspended,
    input  logic       rwu_en,
    output logic       wake_req,
    input  logic       ms_tick,
    input  logic [7:0] lat_cfg,
    input  logic       h_rx_valid,
    input  logic [7:0] h_rx_data,
    output logic       h_rx_ready,
    input  logic       h_in_req,
    output logic       h_tx_valid,
    output logic [7:0] h_tx_data,
    input  logic       h_tx_ready
);
    // synchronized strobes and edge detection
    logic [2:0] syn, syn_d;
    logic       wr_fall, rd_fall, rd_rise, snd_rise;

    fb_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({snd_wake, ext_rd_n, ext_wr_n}), .q(syn)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syn_d <= 3'b011;
        else        syn_d <= syn;
    end

    assign wr_fall  = syn_d[0] && !syn[0];
    assign rd_fall  = syn_d[1] && !syn[1];
    assign rd_rise  = !syn_d[1] && syn[1];
    assign snd_rise = !syn_d[2] && syn[2];

    // buffers
    logic           tx_push, tx_pop, tx_full, tx_empty;
    logic [TCW-1:0] tx_count;
    logic           rx_push, rx_pop, rx_full, rx_empty;
    logic [RCW-1:0] rx_count;
    logic [7:0]     rx_head;

    fb_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_in),
        .pop(tx_pop), .dout(h_tx_data), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    fb_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(h_rx_data),
        .pop(rx_pop), .dout(rx_head), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    assign h_rx_ready = !rx_full;
    assign rx_push    = h_rx_valid && !rx_full;
    assign rx_avail_n = rx_empty;

    // write machine
    wr_state_e wr_st, wr_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_st <= WR_IDLE;
        else        wr_st <= wr_nx;
    end

    always_comb begin
        wr_nx = wr_st;
        unique case (wr_st)
            WR_IDLE:  if (wr_fall && !tx_full) wr_nx = WR_HOLD1;
            WR_HOLD1: wr_nx = WR_HOLD2;
            WR_HOLD2: wr_nx = WR_IDLE;
            default:  wr_nx = WR_IDLE;
        endcase
    end

    always_comb begin
        tx_push = (wr_st == WR_IDLE) && wr_fall && !tx_full;
        tx_busy = (wr_st != WR_IDLE) || tx_full;
    end

    // read machine
    rd_state_e rd_st, rd_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_st <= RD_IDLE;
        else        rd_st <= rd_nx;
    end

    always_comb begin
        rd_nx = rd_st;
        unique case (rd_st)
            RD_IDLE:  if (rd_fall && !rx_empty) rd_nx = RD_DRIVE;
            RD_DRIVE: if (rd_rise) rd_nx = RD_IDLE;
            default:  rd_nx = RD_IDLE;
        endcase
    end

    always_comb begin
        bus_oe  = (rd_st == RD_DRIVE);
        bus_out = rx_head;
        rx_pop  = (rd_st == RD_DRIVE) && rd_rise;
    end

    // flush bookkeeping
    logic           tmr_expire, flush_trig, flush_pend;
    logic [TCW-1:0] flush_left;

    fb_latency #(.DEF_MS(DEF_MS)) u_lat (
        .clk(clk), .rst_n(rst_n), .tick(ms_tick), .restart(tx_push),
        .armed(!tx_empty && !flush_pend), .cfg(lat_cfg), .expire(tmr_expire)
    );

    assign flush_pend = (flush_left != '0);
    assign flush_trig = ((snd_rise && !suspended) || tmr_expire) && !tx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     flush_left <= '0;
        else if (flush_trig)            flush_left <= tx_count - TCW'(tx_pop);
        else if (tx_pop && flush_pend)  flush_left <= flush_left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= snd_rise && suspended && rwu_en;
    end

    // drain machine
    tx_state_e     tx_st, tx_nx;
    logic [SW-1:0] sent;
    logic          tx_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_st <= TX_IDLE;
        else        tx_st <= tx_nx;
    end

    assign tx_last = (sent == SW'(BURST - 1)) || (tx_count == TCW'(1));

    always_comb begin
        tx_nx = tx_st;
        unique case (tx_st)
            TX_IDLE:
                if (h_in_req && !tx_empty && (flush_pend || tx_count >= TCW'(BURST)))
                    tx_nx = TX_BURST;
            TX_BURST:
                if (tx_pop && tx_last) tx_nx = TX_IDLE;
            default: tx_nx = TX_IDLE;
        endcase
    end

    always_comb begin
        h_tx_valid = (tx_st == TX_BURST) && !tx_empty;
        tx_pop     = h_tx_valid && h_tx_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 sent <= '0;
        else if (tx_st == TX_IDLE)  sent <= '0;
        else if (tx_pop)            sent <= sent + 1'b1;
    end
endmodule

// File: rtl/fb_checker.sv
module fb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_push,
    input logic       tx_busy,
    input logic       tx_full,
    input logic       tx_empty,
    input logic       bus_oe,
    input logic [7:0] bus_out,
    input logic       rx_avail_n,
    input logic       wake_req,
    input logic       suspended,
    input logic       rwu_en,
    input logic       h_tx_valid
);
    // R3
    store_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |=> tx_busy);
    // R4
    full_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> tx_busy);
    // R5
    drive_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !rx_avail_n);
    // R5
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_out));
    // R11
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);
    // R12
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(suspended && rwu_en));
    // R6
    tx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_tx_valid |-> !tx_empty);
endmodule

bind fifo_bridge fb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_busy(tx_busy),
    .tx_full(tx_full), .tx_empty(tx_empty), .bus_oe(bus_oe),
    .bus_out(bus_out), .rx_avail_n(rx_avail_n), .wake_req(wake_req),
    .suspended(suspended), .rwu_en(rwu_en), .h_tx_valid(h_tx_valid)
);

// File: tb/tb_fifo_bridge.sv
module tb_fifo_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int RXD = 4, TXD = 8, BST = 3;

    logic clk = 0, rst_n = 0;
    logic ext_wr_n = 1, ext_rd_n = 1, snd_wake = 0, suspended = 0, rwu_en = 0;
    logic ms_tick = 0, h_rx_valid = 0, h_in_req = 0, h_tx_ready = 1;
    logic [7:0] bus_in = 0, lat_cfg = 0, h_rx_data = 0;
    logic [7:0] bus_out, h_tx_data;
    logic bus_oe, rx_avail_n, tx_busy, wake_req, h_rx_ready, h_tx_valid;

    int checks = 0, fails = 0, busy_seen, wake_seen, got;
    bit done = 0;
    int model[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_bridge #(.RX_DEPTH(RXD), .TX_DEPTH(TXD), .BURST(BST), .DEF_MS(16)) dut (
        .clk(clk), .rst_n(rst_n), .ext_wr_n(ext_wr_n), .ext_rd_n(ext_rd_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .rx_avail_n(rx_avail_n), .tx_busy(tx_busy), .snd_wake(snd_wake),
        .suspended(suspended), .rwu_en(rwu_en), .wake_req(wake_req),
        .ms_tick(ms_tick), .lat_cfg(lat_cfg), .h_rx_valid(h_rx_valid),
        .h_rx_data(h_rx_data), .h_rx_ready(h_rx_ready), .h_in_req(h_in_req),
        .h_tx_valid(h_tx_valid), .h_tx_data(h_tx_data), .h_tx_ready(h_tx_ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic ext_write(input logic [7:0] b, input bit accept);
        busy_seen = 0;
        @(negedge clk); bus_in = b; ext_wr_n = 0;
        repeat (6) begin @(negedge clk); busy_seen += int'(tx_busy); end
        ext_wr_n = 1;
        repeat (4) begin @(negedge clk); busy_seen += int'(tx_busy); end
        if (accept) model.push_back(int'(b));
    endtask

    task automatic ext_read(output int val, output bit oe);
        @(negedge clk); ext_rd_n = 0;
        repeat (5) @(negedge clk);
        oe = bus_oe; val = int'(bus_out);
        ext_rd_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_send();
        wake_seen = 0;
        @(negedge clk); snd_wake = 1;
        repeat (5) begin @(negedge clk); wake_seen += int'(wake_req); end
        snd_wake = 0;
        repeat (5) begin @(negedge clk); wake_seen += int'(wake_req); end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1;
            @(negedge clk); ms_tick = 0;
        end
    endtask

    task automatic drain(input string tag);
        int exp;
        got = 0;
        @(negedge clk); h_in_req = 1;
        @(negedge clk); h_in_req = 0;
        repeat (12) begin
            if (h_tx_valid) begin
                exp = (model.size() > 0) ? model.pop_front() : -1;
                check(int'(h_tx_data) == exp, {tag, " data order R3"}, int'(h_tx_data), exp);
                got++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int v; bit oe;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check(!bus_oe && !tx_busy && !h_tx_valid && !wake_req, "R1 outputs low", 1, 0);
        check(rx_avail_n && h_rx_ready, "R1 flags high", 0, 1);

        // R2 fill receive buffer
        for (int i = 0; i < RXD + 1; i++) begin
            @(negedge clk);
            check(h_rx_ready == (i < RXD), "R2 host ready", int'(h_rx_ready), int'(i < RXD));
            h_rx_valid = 1; h_rx_data = 8'hA0 + 8'(i);
            @(negedge clk); h_rx_valid = 0;
            check(!rx_avail_n, "R2 data waiting", int'(rx_avail_n), 0);
        end
        // R5 reads in order
        for (int i = 0; i < RXD; i++) begin
            ext_read(v, oe);
            check(oe, "R5 bus driven", int'(oe), 1);
            check(v == 'hA0 + i, "R5 head byte", v, 'hA0 + i);
        end
        check(rx_avail_n, "R2 empty flag", int'(rx_avail_n), 1);
        ext_read(v, oe);
        check(!oe, "R5 empty read ignored", int'(oe), 0);

        // R3 / R4 fill transmit buffer
        for (int i = 0; i < TXD; i++) begin
            ext_write(8'h10 + 8'(i), 1);
            check(busy_seen >= 2, "R3 storing interval", busy_seen, 2);
        end
        check(tx_busy, "R4 full flag", int'(tx_busy), 1);
        ext_write(8'hEE, 0);
        // R6 bursts
        drain("R6 full");  check(got == BST, "R6 burst1", got, BST);
        drain("R6 second"); check(got == BST, "R6 burst2", got, BST);
        drain("R6 short");  check(got == 0, "R6 below packet", got, 0);
        // R9
        pulse_send();
        drain("R9 flush");  check(got == TXD - 2*BST, "R9 send flush", got, TXD - 2*BST);
        drain("R9 after");  check(got == 0, "R9 nothing left", got, 0);

        // R7 sweep
        for (int L = 1; L <= 4; L++) begin
            lat_cfg = 8'(L);
            ext_write(8'h30 + 8'(L), 1);
            ticks(L - 1);
            drain("R7 early"); check(got == 0, "R7 before limit", got, 0);
            ticks(1);
            drain("R7 expire"); check(got == 1, "R7 at limit", got, 1);
        end
        lat_cfg = 0;
        ext_write(8'h55, 1);
        ticks(15);
        drain("R7 def"); check(got == 0, "R7 default early", got, 0);
        ticks(1);
        drain("R7 def"); check(got == 1, "R7 default limit", got, 1);

        // R8 restart
        lat_cfg = 3;
        ext_write(8'h61, 1); ticks(2);
        ext_write(8'h62, 1); ticks(2);
        drain("R8"); check(got == 0, "R8 restarted", got, 0);
        ticks(1);
        drain("R8"); check(got == 2, "R8 expiry", got, 2);

        // R10 persistence
        lat_cfg = 0;
        for (int i = 0; i < BST + 1; i++) ext_write(8'h70 + 8'(i), 1);
        pulse_send();
        drain("R10"); check(got == BST, "R10 first", got, BST);
        drain("R10"); check(got == 1, "R10 remainder", got, 1);
        drain("R10"); check(got == 0, "R10 cleared", got, 0);

        // R11 / R12 suspend
        suspended = 1; rwu_en = 1;
        ext_write(8'h81, 1);
        pulse_send();
        check(wake_seen == 1, "R11 wake pulse", wake_seen, 1);
        drain("R11"); check(got == 0, "R11 no flush", got, 0);
        rwu_en = 0;
        pulse_send();
        check(wake_seen == 0, "R12 wake gated", wake_seen, 0);
        drain("R12"); check(got == 0, "R12 no flush", got, 0);
        suspended = 0;
        pulse_send();
        check(wake_seen == 0, "R9 no wake active", wake_seen, 0);
        drain("R9"); check(got == 1, "R9 flush one", got, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule